// File: doc/BRIEF.md
# Configurable Column Mixer

This block performs the column-mixing step of an AES round on a single 32-bit column. The matrix coefficients and the field reduction polynomial are not fixed. The circulant matrix is built from a four-byte row vector that arrives on input ports, and the multiplications are done in GF(2^8) under a reduction polynomial that is also an input. Two row vectors are supplied, one for the forward (cipher) direction and one for the inverse (decipher) direction. A per-column direction bit picks between them. Both directions run through the same multiplier hardware.

For each of the four coefficients, the block registers the products coefficient·x^k for k = 0..7, where each step is one xtime under the supplied polynomial. A general GF(2^8) product by a column byte then needs only an XOR of the table entries selected by the bits of that byte. A column presented with `in_valid` comes out two clock edges later with `out_valid`. The row vector, polynomial and direction must be present in the same cycle as the column.

Top module: `cmix_column_xform`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result, `out_valid` is 0 and `col_o` is 0.
- R2: A column sampled with `in_valid` high at a rising edge produces `out_valid` high after the second rising edge that follows. Each accepted column gives exactly one result, results come in input order, and columns may arrive back to back every cycle.
- R3: Byte i of a column sits at bits [8i+7:8i], and coefficient c_k of a row vector sits at bits [8k+7:8k]. Output byte i is the XOR over j of c_((j−i) mod 4)·in_j in GF(2^8). Example: with row 32'h01010302 and polynomial byte 8'h1B, column 32'h455313DB maps to 32'hBCA14D8E, and column 32'h5C220AF2 maps to 32'h9D58DC9F.
- R4: With `dir_inv` = 1 the row vector `inv_row` is used instead of `fwd_row`. With `inv_row` = 32'h090D0B0E and polynomial 8'h1B, each forward result maps back to its original column.
- R5: Any row vector is accepted. Row 32'h00000001 passes the column unchanged. Row 32'h00000100 gives output byte i = input byte (i+1) mod 4. General rows follow the formula in R3.
- R6: `red_poly` holds the polynomial terms below x^8, and x^8 is implied. xtime is a left shift by one bit, followed by an XOR with `red_poly` when the bit shifted out is 1. Products follow this rule for any polynomial byte.
- R7: The row vectors, polynomial and direction are sampled at the same edge as the column. A new setting can therefore change on every column with no idle cycle.
- R8: While no result is due, `col_o` holds the last result, whatever appears on `col_i` and the other inputs.
- R9: An all-zero column yields an all-zero result for every row vector and polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Column on `col_i` is to be transformed |
| dir_inv | input | 1 | 0 selects `fwd_row`, 1 selects `inv_row` |
| col_i | input | 32 | Input column, byte i at bits [8i+7:8i] |
| fwd_row | input | 32 | Forward coefficient row, c_k at bits [8k+7:8k] |
| inv_row | input | 32 | Inverse coefficient row, same layout |
| red_poly | input | 8 | Reduction polynomial terms below x^8 |
| out_valid | output | 1 | `col_o` carries a new result |
| col_o | output | 32 | Mixed column |

## Verification
Every result is due exactly two rising edges after its column is sampled. The driver writes the due cycle next to each expected column in the scoreboard. The monitor samples at the falling edge and compares both the value and the cycle in which `out_valid` rises. In cycles with no result due, the monitor checks that `col_o` still holds the last expected value, while the driver puts unrelated data on the inputs. The settings change together with the column, so each expected value is computed from the row and polynomial driven in that same cycle.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
  localparam int CM_BW = 8;
  localparam int CM_NB = 4;
  localparam int CM_CW = CM_BW * CM_NB;

  typedef logic [CM_BW-1:0] byte_t;
  typedef byte_t [CM_BW-1:0] pow_row_t;

  // one doubling step in GF(2^8) under the supplied low polynomial byte
  function automatic byte_t gf_xtime(input byte_t v, input byte_t red);
    byte_t sh;
    sh = {v[CM_BW-2:0], 1'b0};
    return v[CM_BW-1] ? (sh ^ red) : sh;
  endfunction

  // product by b, given the powers p[k] = a * x^k
  function automatic byte_t gf_pick(input pow_row_t p, input byte_t b);
    byte_t acc;
    acc = '0;
    for (int k = 0; k < CM_BW; k++) begin
      if (b[k]) acc = acc ^ p[k];
    end
    return acc;
  endfunction
endpackage

// File: rtl/cmix_pow_table.sv
module cmix_pow_table
  import cmix_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  byte_t    coef_i,
  input  byte_t    red_i,
  output pow_row_t pow_q
);
  pow_row_t chain;

  assign chain[0] = coef_i;
  for (genvar k = 1; k < CM_BW; k++) begin : g_step
    assign chain[k] = gf_xtime(chain[k-1], red_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pow_q <= '0;
    else        pow_q <= chain;
  end

  AST_ZERO_COEF: assert property (@(posedge clk) disable iff (!rst_n)
    coef_i == '0 |=> pow_q == '0); // R9
endmodule

// File: rtl/cmix_dot_row.sv
module cmix_dot_row
  import cmix_pkg::*;
#(
  parameter int ROW = 0
)(
  input  pow_row_t [CM_NB-1:0] tbl_i,
  input  byte_t    [CM_NB-1:0] col_i,
  output byte_t                byte_o
);
  byte_t [CM_NB-1:0] term;

  for (genvar j = 0; j < CM_NB; j++) begin : g_term
    localparam int CIDX = (j - ROW + CM_NB) % CM_NB;
    assign term[j] = gf_pick(tbl_i[CIDX], col_i[j]);
  end

  always_comb begin
    byte_o = '0;
    for (int j = 0; j < CM_NB; j++) byte_o = byte_o ^ term[j];
  end
endmodule

// File: rtl/cmix_column_xform.sv
module cmix_column_xform
  import cmix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             dir_inv,
  input  logic [CM_CW-1:0] col_i,
  input  logic [CM_CW-1:0] fwd_row,
  input  logic [CM_CW-1:0] inv_row,
  input  logic [CM_BW-1:0] red_poly,
  output logic             out_valid,
  output logic [CM_CW-1:0] col_o
);
  byte_t    [CM_NB-1:0] row_sel;
  pow_row_t [CM_NB-1:0] tbl;
  logic                 s1_valid;
  byte_t    [CM_NB-1:0] s1_col;
  byte_t    [CM_NB-1:0] mix_col;

  // one shared set of tables serves both directions
  assign row_sel = dir_inv ? inv_row : fwd_row;

  for (genvar c = 0; c < CM_NB; c++) begin : g_tbl
    cmix_pow_table u_tbl (
      .clk    (clk),
      .rst_n  (rst_n),
      .coef_i (row_sel[c]),
      .red_i  (red_poly),
      .pow_q  (tbl[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_col   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_col <= col_i;
    end
  end

  for (genvar r = 0; r < CM_NB; r++) begin : g_row
    cmix_dot_row #(.ROW(r)) u_row (
      .tbl_i  (tbl),
      .col_i  (s1_col),
      .byte_o (mix_col[r])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      col_o     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) col_o <= mix_col;
    end
  end

  AST_ACCEPT_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid); // R2
  AST_RESULT_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(col_o)); // R8
  AST_ZERO_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_col == '0) |=> col_o == '0); // R9
endmodule

// File: tb/cmix_column_xform_test.sv
module cmix_column_xform_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        dir_inv = 1'b0;
  logic [31:0] col_i = '0;
  logic [31:0] fwd_row = '0;
  logic [31:0] inv_row = '0;
  logic [7:0]  red_poly = '0;
  logic        out_valid;
  logic [31:0] col_o;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit in_reset = 1;
  bit have_last = 0;
  logic [31:0] last_exp = '0;

  logic [31:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  localparam logic [31:0] STD_FWD = 32'h01010302;
  localparam logic [31:0] STD_INV = 32'h090D0B0E;

  cmix_column_xform uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_inv(dir_inv),
    .col_i(col_i), .fwd_row(fwd_row), .inv_row(inv_row), .red_poly(red_poly),
    .out_valid(out_valid), .col_o(col_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // shift-and-add product, reduced bit by bit
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] p);
    logic [7:0] acc, aa;
    logic [7:0] bb;
    acc = 0; aa = a; bb = b;
    while (bb != 0) begin
      if (bb[0]) acc ^= aa;
      aa = aa[7] ? ((aa << 1) ^ p) : (aa << 1);
      bb = bb >> 1;
    end
    return acc;
  endfunction

  function automatic logic [31:0] ref_mix(input logic [31:0] c, input logic [31:0] row,
                                          input logic [7:0] p);
    logic [31:0] r;
    r = 0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] s;
      s = 0;
      for (int j = 0; j < 4; j++)
        s ^= ref_mul(row[8*((j - i + 4) % 4) +: 8], c[8*j +: 8], p);
      r[8*i +: 8] = s;
    end
    return r;
  endfunction

  task automatic push(input string tag, input logic [31:0] c, input bit d,
                      input logic [31:0] f, input logic [31:0] iv, input logic [7:0] p);
    @(negedge clk);
    in_valid = 1; dir_inv = d; col_i = c; fwd_row = f; inv_row = iv; red_poly = p;
    exp_q.push_back(ref_mix(c, d ? iv : f, p));
    due_q.push_back(cyc + 2);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input logic [31:0] junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0; col_i = junk ^ k; dir_inv = k[0];
      fwd_row = junk + k; red_poly = junk[7:0];
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (in_reset) begin
      checks++;
      if (out_valid !== 1'b0 || col_o !== 32'h0) begin
        bad++;
        $display("FAIL R1 reset state valid=%b col=%h expected valid=0 col=00000000",
                 out_valid, col_o);
      end
    end else if (out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; bad++;
        $display("FAIL R2 unexpected result col=%h expected no result", col_o);
      end else begin
        logic [31:0] e;
        int dcy;
        string t;
        e = exp_q.pop_front(); dcy = due_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if (col_o !== e) begin
          bad++;
          $display("FAIL %s result col=%h expected %h", t, col_o, e);
        end
        checks++;
        if (cyc != dcy) begin
          bad++;
          $display("FAIL R2 latency result at cycle %0d expected cycle %0d", cyc, dcy);
        end
        last_exp = e; have_last = 1;
      end
    end else if (have_last) begin
      checks++;
      if (col_o !== last_exp) begin
        bad++;
        $display("FAIL R8 hold col=%h expected %h", col_o, last_exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk); // R1 after release, before any column
    checks++;
    if (out_valid !== 1'b0 || col_o !== 32'h0) begin
      bad++;
      $display("FAIL R1 after release valid=%b col=%h expected valid=0 col=00000000",
               out_valid, col_o);
    end
    in_reset = 0;

    // R3 standard forward vectors, back to back (R2)
    push("R3", 32'h455313DB, 0, STD_FWD, STD_INV, 8'h1B);
    push("R3", 32'h5C220AF2, 0, STD_FWD, STD_INV, 8'h1B);
    push("R3", 32'h01010101, 0, STD_FWD, STD_INV, 8'h1B);
    push("R3", 32'hC6C6C6C6, 0, STD_FWD, STD_INV, 8'h1B);
    idle(3, 32'hA5A55A5A);   // R8 while idle

    // R4 inverse direction recovers the originals
    push("R4", 32'hBCA14D8E, 1, STD_FWD, STD_INV, 8'h1B);
    push("R4", 32'h9D58DC9F, 1, STD_FWD, STD_INV, 8'h1B);
    push("R4", 32'h01010101, 1, STD_FWD, STD_INV, 8'h1B);
    idle(2, 32'h3C3C0F0F);

    // R9 zero column under several settings
    push("R9", 32'h0, 0, STD_FWD, STD_INV, 8'h1B);
    push("R9", 32'h0, 1, 32'hFFFFFFFF, 32'h77665544, 8'h4D);
    idle(2, 32'h12345678);

    // R5 identity, rotation and general rows
    push("R5", 32'hDEADBEEF, 0, 32'h00000001, STD_INV, 8'h1B);
    push("R5", 32'hDEADBEEF, 0, 32'h00000100, STD_INV, 8'h1B);
    push("R5", 32'h13579BDF, 0, 32'h5A3C9107, STD_INV, 8'h1B);
    push("R5", 32'h2468ACE0, 1, STD_FWD, 32'hE1F20384, 8'h1B);

    // R6 other polynomials
    push("R6", 32'h455313DB, 0, STD_FWD, STD_INV, 8'h1D);
    push("R6", 32'h80808080, 0, 32'h80402010, STD_INV, 8'h2B);
    push("R6", 32'hFFFF0180, 1, STD_FWD, 32'hFE7F8001, 8'hC3);

    // R7 every setting changes on every column, mixed directions
    for (int k = 0; k < 24; k++) begin
      logic [31:0] c, f, iv;
      c  = 32'h9E3779B9 * (k + 1);
      f  = 32'h7F4A7C15 ^ (k * 32'h01010101);
      iv = 32'hC2B2AE35 + k * 32'h00150203;
      push("R7", c, k[0], f, iv, 8'h1B + 8'(k * 17));
    end
    idle(4, 32'h0BADF00D);

    // R8 long idle with changing junk on all inputs
    idle(6, 32'hFEEDFACE);
    done = 1;
    checks++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 %0d results missing expected 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; bad++;
      $display("FAIL R2 watchdog expired expected completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule